// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one atomic memory operation at a time on 32-bit or 64-bit memory words. A command arrives with an already computed byte address, a source operand, the current value of the return register (called R0 below), a size code and an 8-bit operation code. The unit checks that the command is legal. It then takes a lock on a single-port memory, reads the addressed word and computes the new value. It writes the new value back, when the operation calls for a write, and releases the lock. Finally it presents a response. The response holds the value computed for the store, an optional new source-register value and an optional new R0 value.

The command and response sides use valid/ready. A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while the unit is idle. A response is held with all of its fields stable until `rsp_ready` is seen high. No new command is taken before that point, so back-pressure on the response side stalls the command side. The memory side uses plain control pins:
- a lock request that must be granted before any access;
- a one-cycle read strobe, with the data returned under a valid flag;
- a one-cycle write strobe with byte enables.

Top module: `atomic_rmw_unit`

## Requirements
- R1: `cmd_size` selects the width: 2'b00 gives 32-bit and 2'b11 gives 64-bit. The codes 2'b01 (16-bit) and 2'b10 (8-bit) set `rsp_illegal`, and the unit then raises no memory request.
- R2: The simple operations are add 0x00, or 0x40, and 0x50 and xor 0xA0. Each one combines the old memory value with the source, and the sum wraps at the operation width. The result is written back and also shown on `rsp_store_val`.
- R3: Bit 0 of the operation code is the fetch flag. When it is set on a simple operation, `rsp_src_we` is 1 and `rsp_src_val` is the memory value before the update. When it is clear, `rsp_src_we` is 0.
- R4: Exchange (0xE1) stores the source value and returns the old memory value through `rsp_src_val`.
- R5: Compare-exchange (0xF1) writes the source value only when the old memory value equals R0. In both outcomes it sets `rsp_r0_we` with the old value and leaves `rsp_src_we` at 0.
- R6: A compare-exchange whose compare fails still reads the memory but issues no write, and it reports `rsp_wrote` = 0.
- R7: A 32-bit operation computes and compares on the low 32 bits only and returns zero-extended values. Its write enables only byte lanes 0 to 3, so the upper half of the memory word is kept.
- R8: An exchange or compare-exchange without the fetch bit (0xE0, 0xF0), or any other operation code, sets `rsp_illegal`. Such a command makes no memory request and writes no register.
- R9: `mem_rd` and `mem_wr` are raised only while `mem_req` and `mem_gnt` are both high. `mem_req` stays high from the read through the write and drops before the response is shown.
- R10: `cmd_ready` is high only when the unit is idle. A response that has not been taken keeps every field stable until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command accepted this cycle if valid |
| cmd_addr | input | ADDR_W | Byte address of the memory word |
| cmd_src | input | DATA_W | Source operand |
| cmd_r0 | input | DATA_W | Current R0 value for compare-exchange |
| cmd_size | input | 2 | Size code (00 = 32-bit, 11 = 64-bit) |
| cmd_op | input | 8 | Operation code |
| mem_req | output | 1 | Lock request, held across read and write |
| mem_gnt | input | 1 | Lock granted |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_wbe | output | DATA_W/8 | Write byte enables |
| mem_rdata | input | DATA_W | Read data |
| mem_rvalid | input | 1 | Read data valid |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_illegal | output | 1 | Command rejected |
| rsp_wrote | output | 1 | Memory was written |
| rsp_store_val | output | DATA_W | Value computed for the store |
| rsp_src_we | output | 1 | Source register update enable |
| rsp_src_val | output | DATA_W | New source register value |
| rsp_r0_we | output | 1 | R0 update enable |
| rsp_r0_val | output | DATA_W | New R0 value |

## Verification
The assertions check the following on every cycle:
- the memory strobes stay inside a granted lock, at most one at a time;
- the lock is still held in the cycle after the read;
- the unit accepts commands only when idle;
- a held response does not change;
- a rejected command raises no request;
- the source and R0 update enables are never set together.

The arithmetic of each operation, the compare against R0, and the zero-extension and byte-lane masking in 32-bit mode can only be shown by the bench. It sweeps every legal and several illegal operation codes across both sizes. The sweep uses operand patterns that differ only in the upper half, and it varies grant latency and response stalls.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

  typedef enum logic [2:0] {
    AOP_ADD,
    AOP_OR,
    AOP_AND,
    AOP_XOR,
    AOP_XCHG,
    AOP_CMPX
  } aop_e;

  localparam logic [1:0] SZ_WORD  = 2'b00;
  localparam logic [1:0] SZ_DWORD = 2'b11;

  typedef struct packed {
    logic illegal;
    aop_e kind;
    logic fetch;
    logic narrow;
  } adec_t;

endpackage

// File: rtl/atomic_rmw_decode.sv
module atomic_rmw_decode
  import atomic_rmw_pkg::*;
(
  input  logic [7:0] op,
  input  logic [1:0] size,
  output adec_t      dec
);

  logic size_bad;

  assign size_bad = (size != SZ_WORD) && (size != SZ_DWORD);

  always_comb begin
    dec         = '0;
    dec.kind    = AOP_ADD;
    dec.fetch   = op[0];
    dec.narrow  = (size == SZ_WORD);
    dec.illegal = size_bad;
    unique case (op[7:1])
      7'h00: dec.kind = AOP_ADD;
      7'h20: dec.kind = AOP_OR;
      7'h28: dec.kind = AOP_AND;
      7'h50: dec.kind = AOP_XOR;
      7'h70: begin
        dec.kind = AOP_XCHG;
        if (!op[0]) dec.illegal = 1'b1;
      end
      7'h78: begin
        dec.kind = AOP_CMPX;
        if (!op[0]) dec.illegal = 1'b1;
      end
      default: dec.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/atomic_rmw_alu.sv
module atomic_rmw_alu
  import atomic_rmw_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  adec_t              dec,
  input  logic [DATA_W-1:0]  old_val,
  input  logic [DATA_W-1:0]  src_val,
  input  logic [DATA_W-1:0]  r0_val,
  output logic [DATA_W-1:0]  store_val,
  output logic               do_write,
  output logic               src_we,
  output logic [DATA_W-1:0]  src_new,
  output logic               r0_we,
  output logic [DATA_W-1:0]  r0_new
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] old_m, src_m, r0_m, raw;

  // Lanes kept for the selected width: low half only in narrow mode.
  assign keep_mask = dec.narrow ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};
  assign old_m     = old_val & keep_mask;
  assign src_m     = src_val & keep_mask;
  assign r0_m      = r0_val  & keep_mask;

  always_comb begin
    unique case (dec.kind)
      AOP_ADD:  raw = old_m + src_m;
      AOP_OR:   raw = old_m | src_m;
      AOP_AND:  raw = old_m & src_m;
      AOP_XOR:  raw = old_m ^ src_m;
      AOP_XCHG: raw = src_m;
      AOP_CMPX: raw = src_m;
      default:  raw = old_m;
    endcase
  end

  assign store_val = raw & keep_mask;
  assign do_write  = (dec.kind != AOP_CMPX) || (old_m == r0_m);
  assign src_we    = dec.fetch && (dec.kind != AOP_CMPX);
  assign src_new   = old_m;
  assign r0_we     = (dec.kind == AOP_CMPX);
  assign r0_new    = old_m;

endmodule

// File: rtl/atomic_rmw_fsm.sv
module atomic_rmw_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_illegal,
  input  logic mem_gnt,
  input  logic mem_rvalid,
  input  logic rsp_ready,
  output logic cmd_ready,
  output logic cmd_take,
  output logic mem_req,
  output logic mem_rd,
  output logic write_phase,
  output logic old_capture,
  output logic rsp_valid
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCK,
    ST_READ,
    ST_WAIT,
    ST_WRITE,
    ST_RESP
  } st_e;

  st_e state, state_nx;

  assign cmd_ready   = (state == ST_IDLE);
  assign cmd_take    = cmd_ready && cmd_valid;
  assign mem_req     = (state == ST_LOCK) || (state == ST_READ) ||
                       (state == ST_WAIT) || (state == ST_WRITE);
  assign mem_rd      = (state == ST_READ);
  assign write_phase = (state == ST_WRITE);
  assign old_capture = (state == ST_WAIT) && mem_rvalid;
  assign rsp_valid   = (state == ST_RESP);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (cmd_take) state_nx = cmd_illegal ? ST_RESP : ST_LOCK;
      ST_LOCK:  if (mem_gnt) state_nx = ST_READ;
      ST_READ:  state_nx = ST_WAIT;
      ST_WAIT:  if (mem_rvalid) state_nx = ST_WRITE;
      ST_WRITE: state_nx = ST_RESP;
      ST_RESP:  if (rsp_ready) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [DATA_W-1:0]    cmd_src,
  input  logic [DATA_W-1:0]    cmd_r0,
  input  logic [1:0]           cmd_size,
  input  logic [7:0]           cmd_op,
  output logic                 mem_req,
  input  logic                 mem_gnt,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  output logic [DATA_W/8-1:0]  mem_wbe,
  input  logic [DATA_W-1:0]    mem_rdata,
  input  logic                 mem_rvalid,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_illegal,
  output logic                 rsp_wrote,
  output logic [DATA_W-1:0]    rsp_store_val,
  output logic                 rsp_src_we,
  output logic [DATA_W-1:0]    rsp_src_val,
  output logic                 rsp_r0_we,
  output logic [DATA_W-1:0]    rsp_r0_val
);

  localparam int LANES = DATA_W / 8;

  adec_t             dec_in, q_dec;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_src, q_r0, q_old;
  logic              cmd_take, write_phase, old_capture;

  logic [DATA_W-1:0] alu_store, alu_src_new, alu_r0_new;
  logic              alu_do_write, alu_src_we, alu_r0_we;

  atomic_rmw_decode u_dec (
    .op   (cmd_op),
    .size (cmd_size),
    .dec  (dec_in)
  );

  atomic_rmw_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_illegal (dec_in.illegal),
    .mem_gnt     (mem_gnt),
    .mem_rvalid  (mem_rvalid),
    .rsp_ready   (rsp_ready),
    .cmd_ready   (cmd_ready),
    .cmd_take    (cmd_take),
    .mem_req     (mem_req),
    .mem_rd      (mem_rd),
    .write_phase (write_phase),
    .old_capture (old_capture),
    .rsp_valid   (rsp_valid)
  );

  atomic_rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .dec       (q_dec),
    .old_val   (q_old),
    .src_val   (q_src),
    .r0_val    (q_r0),
    .store_val (alu_store),
    .do_write  (alu_do_write),
    .src_we    (alu_src_we),
    .src_new   (alu_src_new),
    .r0_we     (alu_r0_we),
    .r0_new    (alu_r0_new)
  );

  // Command capture and old-value capture.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_dec  <= '0;
      q_addr <= '0;
      q_src  <= '0;
      q_r0   <= '0;
      q_old  <= '0;
    end else begin
      if (cmd_take) begin
        q_dec  <= dec_in;
        q_addr <= cmd_addr;
        q_src  <= cmd_src;
        q_r0   <= cmd_r0;
      end
      if (old_capture) q_old <= mem_rdata;
    end
  end

  // Response registers: loaded at the write step, or at once for a rejected command.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_illegal   <= 1'b0;
      rsp_wrote     <= 1'b0;
      rsp_store_val <= '0;
      rsp_src_we    <= 1'b0;
      rsp_src_val   <= '0;
      rsp_r0_we     <= 1'b0;
      rsp_r0_val    <= '0;
    end else if (cmd_take && dec_in.illegal) begin
      rsp_illegal   <= 1'b1;
      rsp_wrote     <= 1'b0;
      rsp_store_val <= '0;
      rsp_src_we    <= 1'b0;
      rsp_src_val   <= '0;
      rsp_r0_we     <= 1'b0;
      rsp_r0_val    <= '0;
    end else if (write_phase) begin
      rsp_illegal   <= 1'b0;
      rsp_wrote     <= alu_do_write;
      rsp_store_val <= alu_store;
      rsp_src_we    <= alu_src_we;
      rsp_src_val   <= alu_src_new;
      rsp_r0_we     <= alu_r0_we;
      rsp_r0_val    <= alu_r0_new;
    end
  end

  assign mem_wr    = write_phase && alu_do_write;
  assign mem_addr  = q_addr;
  assign mem_wdata = alu_store;

  // Byte lanes: narrow operations touch only the lower half of the word.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mem_wbe[g] = !q_dec.narrow || (g < LANES / 2);
  end

endmodule

// File: rtl/atomic_rmw_chk.sv
module atomic_rmw_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_illegal,
  input logic              rsp_wrote,
  input logic              rsp_src_we,
  input logic [DATA_W-1:0] rsp_src_val,
  input logic              rsp_r0_we,
  input logic [DATA_W-1:0] rsp_r0_val
);

  // R9
  rd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (mem_req && mem_gnt));

  // R9
  wr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_req && mem_gnt));

  // R9
  lock_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_req);

  // R9
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));

  // R10
  idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_req && !rsp_valid));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_src_val) &&
      $stable(rsp_r0_val) && $stable(rsp_illegal) && $stable(rsp_wrote)));

  // R8
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_illegal) |-> (!mem_req && !rsp_src_we && !rsp_r0_we));

  // R5
  we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_src_we && rsp_r0_we));

endmodule

bind atomic_rmw_unit atomic_rmw_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/atomic_rmw_unit_tb_top.sv
`timescale 1ns/1ps
module atomic_rmw_unit_tb_top;

  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_src = '0, cmd_r0 = '0;
  logic [1:0]    cmd_size = '0;
  logic [7:0]    cmd_op = '0;
  logic          mem_req, mem_rd, mem_wr;
  logic          mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [7:0]    mem_wbe;
  logic [DW-1:0] mem_rdata = '0;
  logic          rsp_valid, rsp_ready = 1'b0;
  logic          rsp_illegal, rsp_wrote, rsp_src_we, rsp_r0_we;
  logic [DW-1:0] rsp_store_val, rsp_src_val, rsp_r0_val;

  always #2 clk = ~clk;

  atomic_rmw_unit #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  // Memory and lock model.
  logic [DW-1:0] mem [16];
  int gnt_dly = 0;
  int gnt_cnt = 0;
  int rd_cnt = 0, wr_cnt = 0, req_cnt = 0, lock_err = 0;

  always @(posedge clk) begin
    if (!mem_req) begin
      mem_gnt <= 1'b0;
      gnt_cnt <= 0;
    end else if (gnt_cnt >= gnt_dly) begin
      mem_gnt <= 1'b1;
    end else begin
      gnt_cnt <= gnt_cnt + 1;
    end
    mem_rvalid <= mem_rd;
    if (mem_rd) mem_rdata <= mem[mem_addr[6:3]];
    if (mem_wr) begin
      for (int b = 0; b < 8; b++)
        if (mem_wbe[b]) mem[mem_addr[6:3]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
    if (rst_n) begin
      if (mem_req) req_cnt <= req_cnt + 1;
      if (mem_rd) rd_cnt <= rd_cnt + 1;
      if (mem_wr) wr_cnt <= wr_cnt + 1;
      if ((mem_rd || mem_wr) && !(mem_req && mem_gnt)) lock_err <= lock_err + 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic is_legal_op(input logic [7:0] op);
    case (op)
      8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51, 8'hA0, 8'hA1, 8'hE1, 8'hF1: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_op(input logic [7:0] op, input logic [1:0] sz, input int idx,
                        input logic [DW-1:0] old, input logic [DW-1:0] src,
                        input logic [DW-1:0] r0, input int stall);
    logic [DW-1:0] mask, o, s, r, res, exp_word;
    logic ill, wrote, is32;
    int wait_n;
    is32 = (sz == 2'b00);
    ill  = !((sz == 2'b00) || (sz == 2'b11)) || !is_legal_op(op);
    mask = is32 ? 64'h0000_0000_FFFF_FFFF : {DW{1'b1}};
    o = old & mask; s = src & mask; r = r0 & mask;
    wrote = 1'b1;
    case (op)
      8'h00, 8'h01: res = o + s;
      8'h40, 8'h41: res = o | s;
      8'h50, 8'h51: res = o & s;
      8'hA0, 8'hA1: res = o ^ s;
      8'hF1: begin res = s; wrote = (o == r); end
      default: res = s;
    endcase
    res = res & mask;
    if (!wrote) exp_word = old;
    else exp_word = is32 ? {old[63:32], res[31:0]} : res;

    @(negedge clk);
    mem[idx] = old;
    rd_cnt = 0; wr_cnt = 0; req_cnt = 0; lock_err = 0;
    cmd_addr = AW'(idx * 8); cmd_src = src; cmd_r0 = r0; cmd_size = sz; cmd_op = op;
    cmd_valid = 1'b1;
    wait_n = 0;
    while (!cmd_ready && wait_n < 1000) begin @(negedge clk); wait_n++; end
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid && wait_n < 1000) begin @(negedge clk); wait_n++; end
    if (wait_n >= 1000) begin
      chk("R10 response timeout", 64'd0, 64'd1);
      return;
    end
    for (int k = 0; k < stall; k++) @(negedge clk);
    chk("R10 response held under stall", {63'd0, rsp_valid}, 64'd1);
    if (ill) begin
      chk(sz inside {2'b01, 2'b10} ? "R1 illegal size flag" : "R8 illegal op flag",
          {63'd0, rsp_illegal}, 64'd1);
      chk(sz inside {2'b01, 2'b10} ? "R1 no memory request" : "R8 no memory request",
          64'(req_cnt), 64'd0);
      chk("R8 no register write", {62'd0, rsp_src_we, rsp_r0_we}, 64'd0);
      chk("R8 memory untouched", mem[idx], old);
    end else begin
      chk("R2 legal flag", {63'd0, rsp_illegal}, 64'd0);
      chk(op == 8'hF1 ? (wrote ? "R5 memory after match" : "R6 memory after mismatch")
                      : (op == 8'hE1 ? "R4 memory after exchange" : "R2 memory result"),
          mem[idx], exp_word);
      if (wrote) chk("R2 store value", rsp_store_val, res);
      chk("R6 wrote flag and write count", {62'd0, rsp_wrote, wr_cnt == 1},
          {62'd0, wrote, wrote});
      chk("R6 one read", 64'(rd_cnt), 64'd1);
      chk(op == 8'hE1 ? "R4 source update enable" : "R3 source update enable",
          {63'd0, rsp_src_we}, {63'd0, op[0] && op != 8'hF1});
      if (rsp_src_we) chk(op == 8'hE1 ? "R4 source old value" : "R3 source old value",
                          rsp_src_val, o);
      chk("R5 r0 update enable", {63'd0, rsp_r0_we}, {63'd0, op == 8'hF1});
      if (op == 8'hF1) chk("R5 r0 old value zero-extended", rsp_r0_val, o);
      if (is32) chk("R7 upper half kept", {32'd0, mem[idx][63:32]}, {32'd0, old[63:32]});
      chk("R9 access outside lock", 64'(lock_err), 64'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R9 lock released", {63'd0, mem_req}, 64'd0);
  endtask

  logic [7:0] legal_ops [10] = '{8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51,
                                 8'hA0, 8'hA1, 8'hE1, 8'hF1};
  logic [7:0] bad_ops [5] = '{8'hE0, 8'hF0, 8'h10, 8'h02, 8'hFF};
  logic [DW-1:0] pat_old [4] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_7FFF_FFFF,
                                 64'h1234_5678_9ABC_DEF0, 64'h0};
  logic [DW-1:0] pat_src [4] = '{64'h1, 64'h0000_0001_8000_0001,
                                 64'h0F0F_F0F0_55AA_33CC, 64'hDEAD_BEEF_CAFE_F00D};

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset ready", {63'd0, cmd_ready}, 64'd1);
    chk("R10 reset no response", {63'd0, rsp_valid}, 64'd0);
    chk("R9 reset no request", {63'd0, mem_req}, 64'd0);

    for (int oi = 0; oi < 10; oi++)
      for (int si = 0; si < 2; si++)
        for (int p = 0; p < 4; p++)
          for (int rsel = 0; rsel < 3; rsel++) begin
            logic [DW-1:0] r0v;
            r0v = (rsel == 0) ? pat_old[p] :
                  (rsel == 1) ? (pat_old[p] ^ 64'h1_0000_0000) : (pat_old[p] ^ 64'h1);
            if (legal_ops[oi] == 8'hF1 || rsel == 0) begin
              gnt_dly = p;
              run_op(legal_ops[oi], si == 0 ? 2'b00 : 2'b11, (p * 3 + oi) % 16,
                     pat_old[p], pat_src[p], r0v, p);
            end
          end

    for (int bi = 0; bi < 5; bi++)
      for (int si = 0; si < 2; si++)
        run_op(bad_ops[bi], si == 0 ? 2'b00 : 2'b11, bi, pat_old[2], pat_src[2], 64'd0, bi);

    for (int sz = 1; sz < 3; sz++)
      for (int oi = 0; oi < 10; oi += 3)
        run_op(legal_ops[oi], 2'(sz), oi, pat_old[1], pat_src[1], pat_old[1], 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule